// File: doc/BRIEF.md
# Transmit Fail-Safe Timeout Monitor

This block guards a serial bus terminal against a runaway transmitter. It watches the two complementary line outputs of the Manchester encoder. It measures how long each continuous transmission lasts, counted in clocks of the 12 MHz reference. If a transmission runs past its allowed length (768 µs by default), the block raises a sticky fail-safe flag and a registered kill gate. The surrounding logic uses the gate to hold both line outputs low, and it may also feed the flag to the transmitter's inhibit input.

Short idle stretches do not end a transmission. An idle stretch of up to three microseconds counts as part of the same message, even when a master reset pulse causes it. Only a longer silence ends the message and restarts the measurement. Once the flag is set, only two events release it. One is a single-clock pulse from the decoder saying that a valid command word carrying this terminal's own address has arrived. The other is a master reset that is held low long enough to qualify.

Top module: `fs_timeout_monitor`

## Requirements
- R1: While power-on reset `rst_n` is low, and on the first clock after it is released, `fail_safe` and `out_kill` are both 0.
- R2: A clock counts as active when `line_pos` or `line_neg` (either one, or both) is sampled high. The elapsed count of a message advances by one on each active clock and does not advance on idle clocks.
- R3: `fail_safe` rises after the clock edge on which an active sample would take the elapsed count past LIMIT_CLKS = CLKS_PER_US*LIMIT_US (9216 by default). That is the 9217th active clock of a message. After the 9216th active clock the flag is still 0.
- R4: `out_kill` is a registered output that equals `fail_safe` on every clock.
- R5: An idle run of at most GAP_CLKS = CLKS_PER_US*GAP_US (36) consecutive clocks does not end the message. The elapsed count carries on from where it stopped.
- R6: An idle run of GAP_CLKS+1 (37) consecutive clocks ends the message and sets the elapsed count to zero.
- R7: Once set, `fail_safe` stays 1 whatever the line activity, idle runs or short master reset pulses, until a clear described in R8 or R9 occurs.
- R8: A 1 on `own_cmd_hit` at a clock edge makes `fail_safe` 0 after that edge. A clear takes priority over a set on the same edge.
- R9: `mrst_n` held low for MRST_CLKS = CLKS_PER_US*MRST_MIN_US (12) consecutive clocks clears `fail_safe` on the 12th low clock, and on every further low clock. A low pulse of 11 clocks or fewer has no effect on the flag.
- R10: Master reset leaves the elapsed count and the idle-run measure untouched. A low pulse that sits inside an idle run of 36 clocks or fewer does not restart the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz reference clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| line_pos | input | 1 | Encoder output that drives the positive bus state |
| line_neg | input | 1 | Encoder output that drives the negative bus state |
| own_cmd_hit | input | 1 | One-clock pulse: valid command word with this terminal's address received |
| mrst_n | input | 1 | Master reset, active low; must be held low to qualify |
| fail_safe | output | 1 | Sticky over-length flag |
| out_kill | output | 1 | Registered gate that forces the line outputs low |

## Verification
The bench tests the limit on both sides: 9216 active clocks must leave the flag at 0, and the 9217th must set it. A counter that is off by one fires a clock early or late. Idle runs of exactly 36 and 37 clocks are placed in the middle of a message. A gap tracker with the wrong bound would restart the timer on the shorter gap, or carry the count across the longer one. Master reset pulses of 11 and 12 clocks check the qualifier, and a 12-clock pulse inside a short gap shows that reset does not restart the measurement. A hit and an over-limit activity sample on the same edge expose the wrong choice of priority. Random segments of activity, gaps, hits and reset pulses are compared clock by clock against a model in the bench.

// File: rtl/fs_pkg.sv
package fs_pkg;

   // Width needed to hold values 0..n inclusive.
   function automatic int fs_cnt_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

   // Line sampling variant selected by the top.
   typedef enum logic [0:0] {
      FS_LINE_DIRECT = 1'b0,
      FS_LINE_SYNCED = 1'b1
   } fs_line_mode_e;

endpackage

// File: rtl/fs_line_sense.sv
module fs_line_sense #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_pos,
   input  logic line_neg,
   output logic active
);
   import fs_pkg::*;

   localparam fs_line_mode_e MODE = (SYNC_STAGES > 0) ? FS_LINE_SYNCED : FS_LINE_DIRECT;

   logic raw_act;
   assign raw_act = line_pos | line_neg;

   generate
      if (MODE == FS_LINE_DIRECT) begin : g_direct
         assign active = raw_act;
      end else begin : g_synced
         logic [SYNC_STAGES-1:0] chain;
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  chain[s] <= 1'b0;
               end else if (s == 0) begin
                  chain[s] <= raw_act;
               end else begin
                  chain[s] <= chain[(s > 0) ? s-1 : 0];
               end
            end
         end
         assign active = chain[SYNC_STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/fs_gap_tracker.sv
module fs_gap_tracker #(
   parameter int GAP_CLKS = 36
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic msg_end
);
   import fs_pkg::*;

   localparam int RUN_MAX = GAP_CLKS + 1;
   localparam int RUN_W   = fs_cnt_width(RUN_MAX);
   localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);
   localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(GAP_CLKS);

   logic [RUN_W-1:0] idle_run;

   // The idle clock being sampled now makes the run exceed the allowed gap.
   assign msg_end = !active && (idle_run >= RUN_LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_run <= '0;
      end else if (active) begin
         idle_run <= '0;
      end else if (idle_run != RUN_SAT) begin
         idle_run <= idle_run + RUN_W'(1);
      end
   end

endmodule

// File: rtl/fs_span_counter.sv
module fs_span_counter #(
   parameter int LIMIT_CLKS = 9216
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic msg_end,
   output logic over_limit
);
   import fs_pkg::*;

   localparam int CNT_W = fs_cnt_width(LIMIT_CLKS);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LIMIT_CLKS);

   logic [CNT_W-1:0] span;

   // An active sample arriving with the count already at the limit exceeds it.
   assign over_limit = active && (span == CNT_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         span <= '0;
      end else if (active) begin
         if (span != CNT_TOP) begin
            span <= span + CNT_W'(1);
         end
      end else if (msg_end) begin
         span <= '0;
      end
   end

endmodule

// File: rtl/fs_mrst_qual.sv
module fs_mrst_qual #(
   parameter int MRST_CLKS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mrst_n,
   output logic mrst_clear
);
   import fs_pkg::*;

   localparam int LOW_W = fs_cnt_width(MRST_CLKS);
   localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(MRST_CLKS);
   localparam logic [LOW_W-1:0] LOW_NEED = LOW_W'(MRST_CLKS - 1);

   logic [LOW_W-1:0] low_run;

   assign mrst_clear = !mrst_n && (low_run >= LOW_NEED);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
      end else if (mrst_n) begin
         low_run <= '0;
      end else if (low_run != LOW_SAT) begin
         low_run <= low_run + LOW_W'(1);
      end
   end

endmodule

// File: rtl/fs_timeout_monitor.sv
module fs_timeout_monitor #(
   parameter int CLKS_PER_US = 12,
   parameter int LIMIT_US    = 768,
   parameter int GAP_US      = 3,
   parameter int MRST_MIN_US = 1,
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_pos,
   input  logic line_neg,
   input  logic own_cmd_hit,
   input  logic mrst_n,
   output logic fail_safe,
   output logic out_kill
);

   localparam int LIMIT_CLKS = CLKS_PER_US * LIMIT_US;
   localparam int GAP_CLKS   = CLKS_PER_US * GAP_US;
   localparam int MRST_CLKS  = CLKS_PER_US * MRST_MIN_US;

   generate
      if (CLKS_PER_US < 1) begin : g_bad_rate
         $error("fs_timeout_monitor: CLKS_PER_US must be at least 1");
      end
      if (LIMIT_CLKS <= GAP_CLKS) begin : g_bad_limit
         $error("fs_timeout_monitor: limit must exceed the gap tolerance");
      end
      if (MRST_CLKS < 1) begin : g_bad_mrst
         $error("fs_timeout_monitor: master reset qualification must be at least one clock");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("fs_timeout_monitor: SYNC_STAGES must be 0..4");
      end
   endgenerate

   logic active;
   logic msg_end;
   logic over_limit;
   logic mrst_clear;
   logic flag_d;

   fs_line_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_pos (line_pos),
      .line_neg (line_neg),
      .active   (active)
   );

   fs_gap_tracker #(.GAP_CLKS(GAP_CLKS)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .msg_end (msg_end)
   );

   fs_span_counter #(.LIMIT_CLKS(LIMIT_CLKS)) u_span (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active),
      .msg_end    (msg_end),
      .over_limit (over_limit)
   );

   fs_mrst_qual #(.MRST_CLKS(MRST_CLKS)) u_mrst (
      .clk        (clk),
      .rst_n      (rst_n),
      .mrst_n     (mrst_n),
      .mrst_clear (mrst_clear)
   );

   // Clear wins over set; otherwise the flag is sticky.
   always_comb begin
      if (own_cmd_hit || mrst_clear) begin
         flag_d = 1'b0;
      end else begin
         flag_d = fail_safe || over_limit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail_safe <= 1'b0;
         out_kill  <= 1'b0;
      end else begin
         fail_safe <= flag_d;
         out_kill  <= flag_d;
      end
   end

endmodule

// File: rtl/fs_timeout_checker.sv
module fs_timeout_checker #(
   parameter int CLKS_PER_US = 12,
   parameter int MRST_MIN_US = 1
) (
   input logic clk,
   input logic rst_n,
   input logic line_pos,
   input logic line_neg,
   input logic own_cmd_hit,
   input logic mrst_n,
   input logic fail_safe,
   input logic out_kill
);
   localparam int MRST_CLKS = CLKS_PER_US * MRST_MIN_US;

   int chk_low;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_low <= 0;
      end else if (mrst_n) begin
         chk_low <= 0;
      end else if (chk_low < MRST_CLKS) begin
         chk_low <= chk_low + 1;
      end
   end

   // R3: the flag only rises after an active line sample
   a_r3_rise_needs_activity: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_safe) |-> $past(line_pos || line_neg));

   // R4: kill gate tracks the flag
   a_r4_kill_tracks_flag: assert property (@(posedge clk) disable iff (!rst_n)
      out_kill == fail_safe);

   // R7: flag held while no clear source is present
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_safe && !own_cmd_hit && mrst_n) |=> fail_safe);

   // R8: address-match pulse clears the flag
   a_r8_hit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      own_cmd_hit |=> !fail_safe);

   // R9: qualified master reset clears the flag
   a_r9_mrst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!mrst_n && chk_low >= MRST_CLKS - 1) |=> !fail_safe);

endmodule

bind fs_timeout_monitor fs_timeout_checker #(
   .CLKS_PER_US (CLKS_PER_US),
   .MRST_MIN_US (MRST_MIN_US)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_pos    (line_pos),
   .line_neg    (line_neg),
   .own_cmd_hit (own_cmd_hit),
   .mrst_n      (mrst_n),
   .fail_safe   (fail_safe),
   .out_kill    (out_kill)
);

// File: tb/sim_fs_timeout_monitor.sv
`timescale 1ns/1ps
module sim_fs_timeout_monitor;

   localparam int LIMIT = 9216;
   localparam int GAP   = 36;
   localparam int MRC   = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_pos = 1'b0, line_neg = 1'b0, own_cmd_hit = 1'b0, mrst_n = 1'b1;
   logic fail_safe, out_kill;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference model state
   int m_idle = 0, m_span = 0, m_low = 0;
   bit m_flag = 0;

   always #2 clk = ~clk;

   fs_timeout_monitor u0 (
      .clk(clk), .rst_n(rst_n), .line_pos(line_pos), .line_neg(line_neg),
      .own_cmd_hit(own_cmd_hit), .mrst_n(mrst_n),
      .fail_safe(fail_safe), .out_kill(out_kill)
   );

   function automatic bit next_flag(input bit flag, input bit set, input bit clr);
      return clr ? 1'b0 : (flag | set);
   endfunction

   task automatic model_edge(input bit act, input bit hit, input bit mr_n);
      bit set = 0;
      bit clr;
      int low_new;
      low_new = mr_n ? 0 : ((m_low + 1 > MRC) ? MRC : m_low + 1);
      clr = hit || (!mr_n && low_new >= MRC);
      if (act) begin
         m_idle = 0;
         set = (m_span == LIMIT);
         if (m_span < LIMIT) m_span++;
      end else begin
         if (m_idle < GAP + 1) m_idle++;
         if (m_idle > GAP) m_span = 0;
      end
      m_low  = low_new;
      m_flag = next_flag(m_flag, set, clr);
   endtask

   task automatic check(input string tag, input bit exp);
      checks++;
      if (fail_safe !== exp || out_kill !== exp) begin
         fails++;
         if (fails < 20)
            $display("FAIL %s: fail_safe=%b out_kill=%b expected %b", tag, fail_safe, out_kill, exp);
      end
   endtask

   task automatic step(input bit p, input bit n, input bit h, input bit m, input string tag);
      @(negedge clk);
      line_pos = p; line_neg = n; own_cmd_hit = h; mrst_n = m;
      @(posedge clk);
      model_edge(p | n, h, m);
      #1;
      check(tag, m_flag);
   endtask

   task automatic run(input bit p, input bit n, input int len, input string tag);
      for (int i = 0; i < len; i++) step(p, n, 1'b0, 1'b1, tag);
   endtask

   task automatic idle(input int len, input string tag);
      for (int i = 0; i < len; i++) step(1'b0, 1'b0, 1'b0, 1'b1, tag);
   endtask

   task automatic expect_flag(input string tag, input bit exp);
      checks++;
      if (fail_safe !== exp) begin
         fails++;
         $display("FAIL %s: fail_safe=%b expected %b", tag, fail_safe, exp);
      end
   endtask

   task automatic clear_all(input string tag);
      step(1'b0, 1'b0, 1'b1, 1'b1, tag);
      idle(GAP + 2, tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish, actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      check("R1 during reset", 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 after release", 1'b0);

      // R2/R3: exact limit, alternating which line carries activity
      for (int i = 0; i < LIMIT; i++)
         step(i[0], ~i[0], 1'b0, 1'b1, "R2 either line counts");
      expect_flag("R3 no flag at 9216", 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b1, "R3 9217th sets");
      expect_flag("R3 flag at 9217", 1'b1);
      check("R4 kill follows flag", 1'b1);

      // R7: sticky across a long idle run and new activity
      idle(200, "R7 sticky idle");
      run(1'b0, 1'b1, 50, "R7 sticky active");
      expect_flag("R7 still set", 1'b1);

      // R8: address-match clear
      step(1'b0, 1'b0, 1'b1, 1'b1, "R8 hit clears");
      expect_flag("R8 cleared", 1'b0);
      idle(GAP + 2, "R6 message ends");

      // R5: 36-clock gap is continuous
      run(1'b1, 1'b0, 5000, "R5 first part");
      idle(GAP, "R5 gap 36");
      run(1'b1, 1'b0, LIMIT - 5000, "R5 second part");
      expect_flag("R5 no flag at 9216 across gap", 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1, "R5 set after gap");
      expect_flag("R5 flag after gap", 1'b1);

      // R8 priority: hit with over-limit sample on the same edge
      step(1'b1, 1'b0, 1'b1, 1'b1, "R8 clear beats set");
      expect_flag("R8 priority", 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1, "R3 still over limit");
      expect_flag("R3 re-set while over", 1'b1);
      clear_all("R8 cleanup");

      // R6: 37-clock gap restarts the count
      run(1'b0, 1'b1, 5000, "R6 first part");
      idle(GAP + 1, "R6 gap 37");
      run(1'b0, 1'b1, LIMIT, "R6 fresh message");
      expect_flag("R6 no flag at 9216 after restart", 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1, "R6 9217th");
      expect_flag("R6 flag", 1'b1);

      // R9: 11-clock pulse ignored, 12-clock pulse clears
      for (int i = 0; i < MRC - 1; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R9 short pulse");
      step(1'b0, 1'b0, 1'b0, 1'b1, "R9 release");
      expect_flag("R9 short pulse ignored", 1'b1);
      for (int i = 0; i < MRC; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R9 long pulse");
      expect_flag("R9 cleared by 12 low", 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b1, "R9 release");
      idle(GAP + 2, "R9 gap");

      // R10: reset pulse inside a short gap does not restart the count
      run(1'b1, 1'b1, 5000, "R10 first part");
      idle(10, "R10 pre gap");
      for (int i = 0; i < MRC; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R10 reset in gap");
      idle(10, "R10 post gap");
      run(1'b1, 1'b1, LIMIT - 5000, "R10 second part");
      expect_flag("R10 no flag at 9216", 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1, "R10 9217th");
      expect_flag("R10 count carried through reset", 1'b1);
      clear_all("R10 cleanup");

      // Random segments checked against the model every clock (R2..R10)
      begin
         int cyc = 0;
         while (cyc < 80000) begin
            int kind = $urandom_range(0, 9);
            int len;
            if (kind < 5) begin
               len = $urandom_range(100, 4000);
               for (int i = 0; i < len; i++) begin
                  int sel = $urandom_range(0, 2);
                  step(sel != 1, sel != 0, ($urandom_range(0, 9999) == 0), 1'b1, "R3 random active");
               end
            end else if (kind < 8) begin
               len = $urandom_range(1, 60);
               for (int i = 0; i < len; i++) step(1'b0, 1'b0, 1'b0, 1'b1, "R5 random gap");
            end else if (kind == 8) begin
               len = $urandom_range(1, 20);
               for (int i = 0; i < len; i++) step(1'b0, 1'b0, 1'b0, 1'b0, "R9 random reset");
            end else begin
               len = 1;
               step(1'b0, 1'b0, 1'b1, 1'b1, "R8 random hit");
            end
            cyc += len;
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule